// File: doc/BRIEF.md
# Two-Phase Programmable Divider Controller

This block sequences a programmable frequency divider that runs on a fast oscillator clock. Every division interval lasts N fast cycles, with N between 96 and 159, and is built from fixed-length counting segments followed by one variable-length segment. The fixed part is a single 80-cycle segment when N is at most 133. When N is 134 or larger, the fixed part is three 32-cycle segments. The variable segment covers the rest of the interval.

The variable length is taken from the modulus only near the end of the fixed part. A control loop therefore has most of the interval to compute the next modulus, and only needs to deliver it shortly before the variable segment begins.

A one-cycle pulse marks the last cycle of each interval. A slow clock tap, taken from the segment counter, runs at about one eighth of the fast clock and can pace downstream logic. A sticky flag records any modulus that could not be used in the interval in which it arrived.

Top module: `twophase_divctl`

## Requirements
- R1: While reset is held, `divOut` and `lateFlag` are 0. After release, the first interval uses the reset modulus (default 120), so its pulse appears in the 120th cycle.
- R2: The distance from one pulse to the next equals the modulus in force, counting the pulse cycle itself. `divOut` is high for exactly one cycle, and that cycle is the last cycle of the interval.
- R3: For a modulus of 133 or less, the interval is one 80-cycle fixed segment followed by a variable segment of N-80 cycles.
- R4: For a modulus of 134 or more, the interval is three 32-cycle fixed segments followed by a variable segment of N-96 cycles.
- R5: The deadline is zero-based position F-8 within the interval, where F is the fixed total (80 or 96). A load strobed at or before the deadline sets the length of the current interval, provided the new value falls in the same range class as the running fixed pattern.
- R6: A load strobed after the deadline takes effect from the next interval, and it sets `lateFlag`. The flag stays set until reset.
- R7: A timely load whose range class differs from the running pattern is also deferred to the next interval and sets `lateFlag`.
- R8: A requested modulus below 96 is used as 96, and one above 159 is used as 159.
- R9: `slowClk` equals bit 2 of the cycle count within the current segment. This count restarts at 0 on each segment boundary, which gives a period of 8 inside fixed segments.
- R10: When several loads arrive before the value is applied, the most recent one is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator clock |
| rstN | input | 1 | Active-low synchronous reset |
| modIn | input | 8 | Requested modulus |
| modLoad | input | 1 | One-cycle strobe that captures `modIn` |
| divOut | output | 1 | High in the last cycle of each interval |
| slowClk | output | 1 | Slow clock tap from segment count bit 2 |
| lateFlag | output | 1 | Sticky: a load missed its interval |

## Verification
A corrupted segment counter or a wrong segment kind changes the phase of `slowClk` within eight cycles. It also moves the next `divOut` pulse, at the latest by the end of the interval. A wrong commit decision shows as an interval length that differs from the modulus in the very next pulse spacing, or as a wrongly set `lateFlag` one cycle after the deadline. The bench therefore compares all three outputs against an independent position model in every cycle, and also measures whole interval lengths.

// File: rtl/divctl_pkg.sv
package divctl_pkg;
  localparam int MOD_W = 8;
  localparam int CNT_W = 7;

  typedef enum logic [1:0] {
    SEG_LONG  = 2'd0,
    SEG_SHORT = 2'd1,
    SEG_VAR   = 2'd2
  } segKind_t;

  // strobe bundle from control to segment datapath
  typedef struct packed {
    logic             restart;
    logic [CNT_W-1:0] len;
  } segCmd_t;
endpackage

// File: rtl/divctl_seg.sv
module divctl_seg
  import divctl_pkg::*;
#(
  parameter int RESET_LEN = 80,
  parameter int LOAD_LEAD = 8,
  parameter int SLOW_DIV  = 8,
  parameter int MIN_LEN   = 16,
  parameter int MAX_LEN   = 80
) (
  input  logic    clk,
  input  logic    rstN,
  input  segCmd_t cmd,
  output logic    segLast,
  output logic    leadPt,
  output logic    pastLead,
  output logic    slowClk
);
  localparam int SLOW_BIT = $clog2(SLOW_DIV) - 1;

  logic [CNT_W-1:0] segCnt;
  logic [CNT_W-1:0] segLen;
  logic [CNT_W-1:0] leadPos;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      segCnt <= '0;
      segLen <= CNT_W'(RESET_LEN);
    end else if (cmd.restart) begin
      segCnt <= '0;
      segLen <= cmd.len;
    end else begin
      segCnt <= segCnt + 1'b1;
    end
  end

  always_comb begin
    leadPos  = segLen - CNT_W'(LOAD_LEAD);
    segLast  = (segCnt == segLen - 1'b1);
    leadPt   = (segCnt == leadPos);
    pastLead = (segCnt > leadPos);
    slowClk  = segCnt[SLOW_BIT];
  end

  // R3/R4: every loaded segment length fits the counter range
  p_len_fits_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.restart |=> (segLen >= CNT_W'(MIN_LEN)) && (segLen <= CNT_W'(MAX_LEN)));

  // R2: the count never runs past the segment end
  p_cnt_in_seg_r2: assert property (@(posedge clk) disable iff (!rstN)
    segCnt < segLen);
endmodule

// File: rtl/divctl_loader.sv
module divctl_loader
  import divctl_pkg::*;
#(
  parameter int MOD_MIN   = 96,
  parameter int MOD_MAX   = 159,
  parameter int HI_MIN    = 134,
  parameter int RESET_MOD = 120
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [MOD_W-1:0] modIn,
  input  logic             modLoad,
  input  logic             commitPt,
  input  logic             intervalEnd,
  input  logic             lateWin,
  input  logic             modeHi,
  output logic [MOD_W-1:0] actMod,
  output logic [MOD_W-1:0] nextMod,
  output logic             lateFlag
);
  logic [MOD_W-1:0] clampVal;
  logic [MOD_W-1:0] pendVal;
  logic             pendValid;
  logic [MOD_W-1:0] effVal;
  logic             effValid;
  logic             effHi;
  logic             classMatch;

  always_comb begin
    if (modIn < MOD_W'(MOD_MIN))       clampVal = MOD_W'(MOD_MIN);
    else if (modIn > MOD_W'(MOD_MAX))  clampVal = MOD_W'(MOD_MAX);
    else                               clampVal = modIn;
    effValid   = modLoad | pendValid;
    effVal     = modLoad ? clampVal : pendVal;
    effHi      = (effVal >= MOD_W'(HI_MIN));
    classMatch = (effHi == modeHi);
    nextMod    = effValid ? effVal : actMod;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actMod    <= MOD_W'(RESET_MOD);
      pendVal   <= MOD_W'(RESET_MOD);
      pendValid <= 1'b0;
      lateFlag  <= 1'b0;
    end else begin
      if (modLoad) begin
        pendValid <= 1'b1;
        pendVal   <= clampVal;
      end
      if (commitPt && effValid && classMatch) begin
        actMod    <= effVal;
        pendValid <= 1'b0;
      end
      if (intervalEnd && effValid) begin
        actMod    <= effVal;
        pendValid <= 1'b0;
      end
      if ((modLoad && lateWin) || (commitPt && effValid && !classMatch))
        lateFlag <= 1'b1;
    end
  end

  // R8: the modulus in force always stays within the legal range
  p_act_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    (actMod >= MOD_W'(MOD_MIN)) && (actMod <= MOD_W'(MOD_MAX)));

  // R7: inside an interval the modulus never changes range class
  p_class_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !intervalEnd |=> ((actMod >= MOD_W'(HI_MIN)) == ($past(actMod) >= MOD_W'(HI_MIN))));

  // R6: the late flag is sticky
  p_late_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    lateFlag |=> lateFlag);
endmodule

// File: rtl/divctl_ctrl.sv
module divctl_ctrl
  import divctl_pkg::*;
#(
  parameter int HI_MIN     = 134,
  parameter int LONG_SEG   = 80,
  parameter int SHORT_SEG  = 32,
  parameter int SHORT_REPS = 3,
  parameter bit RESET_HI   = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             segLast,
  input  logic             leadPt,
  input  logic             pastLead,
  input  logic [MOD_W-1:0] actMod,
  input  logic [MOD_W-1:0] nextMod,
  output segCmd_t          cmd,
  output logic             commitPt,
  output logic             lateWin,
  output logic             intervalEnd,
  output logic             modeHi
);
  localparam int REP_W   = (SHORT_REPS > 1) ? $clog2(SHORT_REPS) : 1;
  localparam int FIX_HI  = SHORT_SEG * SHORT_REPS;

  segKind_t         kind, kindNext;
  logic [REP_W-1:0] rep, repNext;
  logic             modeHiNext;
  logic             lastFixed;
  logic             nextHi;
  logic [CNT_W-1:0] lenNext;

  always_comb begin
    lastFixed   = (kind == SEG_LONG) ||
                  ((kind == SEG_SHORT) && (rep == REP_W'(SHORT_REPS - 1)));
    commitPt    = lastFixed && leadPt;
    lateWin     = (kind == SEG_VAR) || (lastFixed && pastLead);
    intervalEnd = (kind == SEG_VAR) && segLast;
    nextHi      = (nextMod >= MOD_W'(HI_MIN));

    kindNext   = kind;
    repNext    = rep;
    modeHiNext = modeHi;
    lenNext    = CNT_W'(LONG_SEG);
    case (kind)
      SEG_LONG: begin
        kindNext = SEG_VAR;
        lenNext  = CNT_W'(actMod) - CNT_W'(LONG_SEG);
      end
      SEG_SHORT: begin
        if (rep == REP_W'(SHORT_REPS - 1)) begin
          kindNext = SEG_VAR;
          lenNext  = CNT_W'(actMod) - CNT_W'(FIX_HI);
        end else begin
          repNext = rep + 1'b1;
          lenNext = CNT_W'(SHORT_SEG);
        end
      end
      SEG_VAR: begin
        modeHiNext = nextHi;
        repNext    = '0;
        kindNext   = nextHi ? SEG_SHORT : SEG_LONG;
        lenNext    = nextHi ? CNT_W'(SHORT_SEG) : CNT_W'(LONG_SEG);
      end
      default: begin
        kindNext = SEG_LONG;
        repNext  = '0;
      end
    endcase

    cmd.restart = segLast;
    cmd.len     = lenNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kind   <= RESET_HI ? SEG_SHORT : SEG_LONG;
      rep    <= '0;
      modeHi <= RESET_HI;
    end else if (segLast) begin
      kind   <= kindNext;
      rep    <= repNext;
      modeHi <= modeHiNext;
    end
  end

  // R2: the interval pulse lasts a single cycle
  p_div_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    intervalEnd |=> !intervalEnd);

  // R3/R4: the short pattern only runs in the high range class
  p_short_hi_r4: assert property (@(posedge clk) disable iff (!rstN)
    (kind == SEG_SHORT) |-> modeHi);

  // R5: commit point never overlaps the late window
  p_commit_window_r5: assert property (@(posedge clk) disable iff (!rstN)
    commitPt |-> !lateWin);
endmodule

// File: rtl/twophase_divctl.sv
module twophase_divctl
  import divctl_pkg::*;
#(
  parameter int MOD_MIN    = 96,
  parameter int MOD_MAX    = 159,
  parameter int HI_MIN     = 134,
  parameter int LONG_SEG   = 80,
  parameter int SHORT_SEG  = 32,
  parameter int SHORT_REPS = 3,
  parameter int LOAD_LEAD  = 8,
  parameter int SLOW_DIV   = 8,
  parameter int RESET_MOD  = 120
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] modIn,
  input  logic       modLoad,
  output logic       divOut,
  output logic       slowClk,
  output logic       lateFlag
);
  localparam bit RESET_HI  = (RESET_MOD >= HI_MIN);
  localparam int RESET_LEN = RESET_HI ? SHORT_SEG : LONG_SEG;
  localparam int MIN_LEN   = MOD_MIN - LONG_SEG;
  localparam int MAX_LEN   = LONG_SEG;

  segCmd_t          cmd;
  logic             segLast, leadPt, pastLead;
  logic             commitPt, lateWin, intervalEnd, modeHi;
  logic [MOD_W-1:0] actMod, nextMod;

  divctl_seg #(
    .RESET_LEN(RESET_LEN), .LOAD_LEAD(LOAD_LEAD), .SLOW_DIV(SLOW_DIV),
    .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)
  ) u_seg (
    .clk(clk), .rstN(rstN), .cmd(cmd), .segLast(segLast),
    .leadPt(leadPt), .pastLead(pastLead), .slowClk(slowClk)
  );

  divctl_ctrl #(
    .HI_MIN(HI_MIN), .LONG_SEG(LONG_SEG), .SHORT_SEG(SHORT_SEG),
    .SHORT_REPS(SHORT_REPS), .RESET_HI(RESET_HI)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .segLast(segLast), .leadPt(leadPt),
    .pastLead(pastLead), .actMod(actMod), .nextMod(nextMod), .cmd(cmd),
    .commitPt(commitPt), .lateWin(lateWin), .intervalEnd(intervalEnd),
    .modeHi(modeHi)
  );

  divctl_loader #(
    .MOD_MIN(MOD_MIN), .MOD_MAX(MOD_MAX), .HI_MIN(HI_MIN), .RESET_MOD(RESET_MOD)
  ) u_loader (
    .clk(clk), .rstN(rstN), .modIn(modIn), .modLoad(modLoad),
    .commitPt(commitPt), .intervalEnd(intervalEnd), .lateWin(lateWin),
    .modeHi(modeHi), .actMod(actMod), .nextMod(nextMod), .lateFlag(lateFlag)
  );

  assign divOut = intervalEnd;
endmodule

// File: tb/twophase_divctl_bench.sv
module twophase_divctl_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] modIn = 8'd0;
  logic       modLoad = 1'b0;
  logic       divOut, slowClk, lateFlag;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  // reference model state
  int mA, mPos, mPval;
  bit mPV, mHi, mLate;

  twophase_divctl u_twophase_divctl (
    .clk(clk), .rstN(rstN), .modIn(modIn), .modLoad(modLoad),
    .divOut(divOut), .slowClk(slowClk), .lateFlag(lateFlag)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected < 150000", cycles);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (pos %0d)", req, act, exp, mPos);
    end
  endtask

  function automatic int clampMod(input int v);
    if (v < 96) return 96;
    if (v > 159) return 159;
    return v;
  endfunction

  function automatic int expSlow();
    int loc;
    if (mHi) loc = (mPos < 96) ? (mPos % 32) : (mPos - 96);
    else     loc = (mPos < 80) ? mPos : (mPos - 80);
    return (loc >> 2) & 1;
  endfunction

  task automatic modelReset();
    mA = 120; mPos = 0; mPval = 0; mPV = 0; mHi = 0; mLate = 0;
  endtask

  // compare outputs at negedge, drive inputs, advance one cycle
  task automatic step(input bit ld, input int v);
    int fixT, cv, effVal;
    bit effV;
    check("R2 divOut", int'(divOut), int'(mPos == mA - 1));
    check("R9 slowClk", int'(slowClk), expSlow());
    check("R6 lateFlag", int'(lateFlag), int'(mLate));
    modLoad = ld;
    modIn   = 8'(v);
    @(posedge clk);
    fixT   = mHi ? 96 : 80;
    cv     = clampMod(v);
    effV   = ld || mPV;
    effVal = ld ? cv : mPval;
    if (ld) begin
      mPV = 1; mPval = cv;
      if (mPos > fixT - 8) mLate = 1;
    end
    if (mPos == fixT - 8 && effV) begin
      if ((effVal >= 134) == mHi) begin mA = effVal; mPV = 0; end
      else mLate = 1;
    end
    if (mPos == mA - 1) begin
      if (effV) begin mA = effVal; mPV = 0; end
      mHi = (mA >= 134);
      mPos = 0;
    end else begin
      mPos++;
    end
    @(negedge clk);
    modLoad = 1'b0;
  endtask

  task automatic toStart();
    while (mPos != 0) step(0, 0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset divOut", int'(divOut), 0);
    check("R1 reset lateFlag", int'(lateFlag), 0);
    rstN = 1'b1;
    modelReset();
  endtask

  // run one interval from its start with up to two loads, check its length
  task automatic runInterval(input int p1, input int v1, input int p2, input int v2,
                             input int expLen, input string req);
    int len = 0;
    toStart();
    for (int i = 0; i < 400; i++) begin
      bit obs = divOut;
      bit ld  = (i == p1) || (i == p2);
      step(ld, (i == p2) ? v2 : v1);
      if (obs) begin len = i + 1; break; end
    end
    check(req, len, expLen);
  endtask

  task automatic tReset();
    doReset();
    check("R1 first cycle divOut", int'(divOut), 0);
    runInterval(-1, 0, -1, 0, 120, "R1 reset modulus length");
    runInterval(-1, 0, -1, 0, 120, "R2 steady length");
  endtask

  task automatic tModeLow();
    runInterval(10, 100, -1, 0, 100, "R5 early load R3");
    runInterval(-1, 0, -1, 0, 100, "R2 repeat length");
    runInterval(72, 110, -1, 0, 110, "R5 load at deadline");
    check("R5 no flag for timely load", int'(lateFlag), 0);
    runInterval(72, 133, -1, 0, 133, "R3 top of low range");
  endtask

  task automatic tLate();
    runInterval(73, 130, -1, 0, 133, "R6 late load deferred");
    check("R6 flag after late load", int'(lateFlag), 1);
    runInterval(-1, 0, -1, 0, 130, "R6 late load next interval");
    check("R6 flag sticky", int'(lateFlag), 1);
  endtask

  task automatic tModeHigh();
    doReset();
    runInterval(5, 150, -1, 0, 120, "R7 class change deferred");
    check("R7 flag on class change", int'(lateFlag), 1);
    runInterval(-1, 0, -1, 0, 150, "R4 short pattern length");
    runInterval(88, 140, -1, 0, 140, "R5 high-range deadline R4");
  endtask

  task automatic tClamp();
    runInterval(88, 200, -1, 0, 159, "R8 clamp high");
    runInterval(20, 20, -1, 0, 159, "R8 low value deferred");
    runInterval(-1, 0, -1, 0, 96, "R8 clamp low");
  endtask

  task automatic tLastWins();
    doReset();
    runInterval(3, 104, 40, 112, 112, "R10 last load wins");
    check("R10 no flag", int'(lateFlag), 0);
  endtask

  initial begin
    modelReset();
    tReset();
    tModeLow();
    tLate();
    tModeHigh();
    tClamp();
    tLastWins();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule